// File: doc/BRIEF.md
# Masked Sticky Status Event Register

This block watches a small set of live instrument status conditions and records, in an 8-bit event register, every enabled condition that has changed since the host last looked. The host chooses which status bits it cares about by writing an 8-bit enable mask. A change of an enabled condition sets the matching event bit whether the condition turned on or off, and the bit then stays set until the host reads the register or issues a clear. A separate front-panel button pulse, which switches the unit to local operation, drives the top bit of the event register.

Whenever an event bit newly goes from 0 to 1, the block emits a one-cycle service-request pulse so the host can be interrupted instead of polling. Bit positions that carry no status are hard-wired to zero in both the enable and event registers. Reading the event register returns its contents and clears it at the same clock edge, without losing a change that arrives in that very cycle.

Top module: `stat_event_top`

## Requirements
- R1: Condition input `cond_i[k]` for k = 0..3 maps to enable and event bit k (0 constant voltage, 1 constant current, 2 no fault, 3 fault active); bit 7 is the local-mode bit. Several bits may set at one edge.
- R2: Bits 6..4 of `en_o` and of `evt_o` always read zero; writing ones to them has no effect.
- R3: A cycle with `en_we_i` high loads `en_wdata_i` (bits 6..4 dropped) into the enable register, visible on `en_o` after that clock edge; without `en_we_i` the enable register holds.
- R4: Event bit k (k = 0..3) sets at the clock edge where `cond_i[k]` differs from its value at the previous edge, for a rising or a falling change, provided enable bit k is 1; changes of disabled bits leave `evt_o` unchanged.
- R5: A set event bit stays set after its condition returns to its former value, until a read or clear.
- R6: A cycle with `lcl_press_i` high and enable bit 7 set sets event bit 7 at that edge; with enable bit 7 clear the press has no effect.
- R7: In a cycle with `evt_rd_i` high, `evt_o` shows the register contents, and after that edge all bits are cleared; `clr_i` clears the same way.
- R8: An enabled change or press arriving in the same cycle as a read or clear leaves its event bit set after the edge.
- R9: `srq_o` is high for exactly the cycle after an edge at which at least one event bit went from 0 to 1, and low otherwise, including when only already-set bits are hit again.
- R10: While the enable register is 00, no event bit sets and `srq_o` stays low.
- R11: Synchronous reset clears the event register, the enable register and `srq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Live status condition bits |
| lcl_press_i | input | 1 | One-cycle pulse: front-panel switch to local operation |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| evt_rd_i | input | 1 | Event register read strobe (clears after the edge) |
| clr_i | input | 1 | Clear command for the event register |
| evt_o | output | 8 | Event register contents |
| en_o | output | 8 | Enable register contents |
| srq_o | output | 1 | One-cycle service-request pulse |

## Verification
The bench drives falling as well as rising condition changes, since a design that compared against a level rather than the previous sample would miss the falling case. It collides a read or a clear with a fresh enabled change, where a design giving the clear priority would lose the event, and it re-hits an already-set bit during a clear, where a design deriving the request from the hit rather than from a register bit transition would raise a spurious request. It also writes ones to the reserved bits and drives every input with an all-zero mask, which exposes a mask that leaks or a request that fires with nothing enabled.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;

  localparam int STAT_W  = 8;
  localparam int COND_W  = 4;
  localparam int LCL_POS = 7;

  // Bits that carry status: the condition bits and the local-mode bit
  function automatic logic [31:0] impl_mask(input int cw, input int lp);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < cw; i++) m[i] = 1'b1;
    m[lp] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/stat_cond_delta.sv
module stat_cond_delta #(
  parameter int COND_W = 4
) (
  input  logic              clk_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [COND_W-1:0] delta_o
);

  logic [COND_W-1:0] prev_q;

  // Previous sample; tracked through reset so no false change follows it
  always_ff @(posedge clk_i) begin
    prev_q <= cond_i;
  end

  assign delta_o = cond_i ^ prev_q;

endmodule

// File: rtl/stat_enable_reg.sv
module stat_enable_reg #(
  parameter int          STAT_W = 8,
  parameter logic [STAT_W-1:0] IMPL = '1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] en_o
);

  logic [STAT_W-1:0] en_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)     en_q <= '0;
    else if (we_i) en_q <= wdata_i & IMPL;
  end

  assign en_o = en_q;

  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !we_i |=> $stable(en_o));

endmodule

// File: rtl/stat_event_latch.sv
module stat_event_latch #(
  parameter int STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [STAT_W-1:0] hit_i,
  input  logic              clear_i,
  output logic [STAT_W-1:0] evt_o,
  output logic              srq_o
);

  logic [STAT_W-1:0] evt_q;
  logic [STAT_W-1:0] evt_next;
  logic [STAT_W-1:0] rise;
  logic              srq_q;

  // New hits are merged after the clear so a coincident event survives
  always_comb begin
    evt_next = (clear_i ? '0 : evt_q) | hit_i;
    rise     = evt_next & ~evt_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      evt_q <= '0;
      srq_q <= 1'b0;
    end else begin
      evt_q <= evt_next;
      srq_q <= |rise;
    end
  end

  assign evt_o = evt_q;
  assign srq_o = srq_q;

  // R5
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !clear_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R7 R8
  evt_clear_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    clear_i |=> (evt_q == $past(hit_i)));

  // R9
  srq_has_evt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    srq_o |-> (evt_q != '0));

endmodule

// File: rtl/stat_event_top.sv
module stat_event_top
  import stat_evt_pkg::*;
#(
  parameter int COND_W  = stat_evt_pkg::COND_W,
  parameter int STAT_W  = stat_evt_pkg::STAT_W,
  parameter int LCL_POS = stat_evt_pkg::LCL_POS
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              lcl_press_i,
  input  logic              en_we_i,
  input  logic [STAT_W-1:0] en_wdata_i,
  input  logic              evt_rd_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] evt_o,
  output logic [STAT_W-1:0] en_o,
  output logic              srq_o
);

  localparam logic [31:0]       MASK32 = impl_mask(COND_W, LCL_POS);
  localparam logic [STAT_W-1:0] IMPL   = MASK32[STAT_W-1:0];

  logic [COND_W-1:0] delta;
  logic [STAT_W-1:0] en;
  logic [STAT_W-1:0] hit;
  logic [STAT_W-1:0] evt;
  logic              srq;
  logic              clear;

  stat_cond_delta #(.COND_W(COND_W)) u_delta (
    .clk_i   (clk_i),
    .cond_i  (cond_i),
    .delta_o (delta)
  );

  stat_enable_reg #(.STAT_W(STAT_W), .IMPL(IMPL)) u_enable (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .en_o    (en)
  );

  // Per-bit set sources: condition changes, the local button, or nothing
  for (genvar b = 0; b < STAT_W; b++) begin : g_hit
    if (b < COND_W) begin : g_cond
      assign hit[b] = delta[b] & en[b];
    end else if (b == LCL_POS) begin : g_lcl
      assign hit[b] = lcl_press_i & en[b];
    end else begin : g_rsvd
      assign hit[b] = 1'b0;
    end
  end

  assign clear = evt_rd_i | clr_i;

  stat_event_latch #(.STAT_W(STAT_W)) u_latch (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .hit_i   (hit),
    .clear_i (clear),
    .evt_o   (evt),
    .srq_o   (srq)
  );

  assign evt_o = evt;
  assign en_o  = en;
  assign srq_o = srq;

  // R10
  no_srq_zero_en_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_o == '0) |=> !srq_o);

  // R9
  srq_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    srq_o == ((evt_o & ~$past(evt_o)) != '0));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((evt_o | en_o) & ~IMPL) == '0);

endmodule

// File: tb/test_stat_event_top.sv
module test_stat_event_top;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [3:0] cond_i = '0;
  logic       lcl_press_i = 1'b0;
  logic       en_we_i = 1'b0;
  logic [7:0] en_wdata_i = '0;
  logic       evt_rd_i = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] evt_o;
  logic [7:0] en_o;
  logic       srq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stat_event_top i_stat_event_top (
    .clk_i(clk_i), .rst_i(rst_i), .cond_i(cond_i), .lcl_press_i(lcl_press_i),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i), .evt_rd_i(evt_rd_i),
    .clr_i(clr_i), .evt_o(evt_o), .en_o(en_o), .srq_o(srq_o)
  );

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_we_i = 1'b1; en_wdata_i = v;
    step();
    en_we_i = 1'b0;
  endtask

  task automatic clear_all();
    clr_i = 1'b1;
    step();
    clr_i = 1'b0;
  endtask

  task automatic t_reset();
    cond_i = 4'b0101;
    repeat (3) step();
    rst_i = 1'b0;
    cond_i = 4'b0000;
    step();
    chk("R11 evt after reset", evt_o, 8'h00);
    chk("R11 en after reset", en_o, 8'h00);
    chk("R11 srq after reset", srq_o, 1'b0);
  endtask

  task automatic t_enable();
    wr_en(8'h70);
    chk("R2 reserved enable bits", en_o, 8'h00);
    wr_en(8'hA5);
    chk("R3 enable write", en_o, 8'h85);
    step();
    chk("R3 enable hold", en_o, 8'h85);
    wr_en(8'hFF);
    chk("R2 enable all ones", en_o, 8'h8F);
  endtask

  task automatic t_mask_edges();
    clear_all();
    wr_en(8'h01);
    cond_i = 4'b0010; step();
    chk("R4 disabled change evt", evt_o, 8'h00);
    chk("R4 disabled change srq", srq_o, 1'b0);
    cond_i = 4'b0011; step();
    chk("R4 rising change", evt_o, 8'h01);
    chk("R9 srq pulse high", srq_o, 1'b1);
    step();
    chk("R9 srq one cycle", srq_o, 1'b0);
    cond_i = 4'b0010; step();
    chk("R5 sticky", evt_o, 8'h01);
    chk("R9 no srq on reset bit", srq_o, 1'b0);
    evt_rd_i = 1'b1;
    chk("R7 read shows contents", evt_o, 8'h01);
    step();
    evt_rd_i = 1'b0;
    chk("R7 cleared after read", evt_o, 8'h00);
    cond_i = 4'b0000; step();
    chk("R4 disabled falling", evt_o, 8'h00);
  endtask

  task automatic t_falling();
    wr_en(8'h00);
    cond_i = 4'b1000; step();
    wr_en(8'h08);
    chk("R4 no event before change", evt_o, 8'h00);
    cond_i = 4'b0000; step();
    chk("R4 falling change", evt_o, 8'h08);
    chk("R9 srq on falling", srq_o, 1'b1);
    clear_all();
    chk("R7 clear command", evt_o, 8'h00);
  endtask

  task automatic t_local();
    wr_en(8'h80);
    lcl_press_i = 1'b1; step(); lcl_press_i = 1'b0;
    chk("R6 local press", evt_o, 8'h80);
    chk("R6 local srq", srq_o, 1'b1);
    clear_all();
    wr_en(8'h0F);
    lcl_press_i = 1'b1; step(); lcl_press_i = 1'b0;
    chk("R6 local disabled", evt_o, 8'h00);
    chk("R6 local disabled srq", srq_o, 1'b0);
  endtask

  task automatic t_multi();
    wr_en(8'hFF);
    cond_i = 4'b1111; step();
    chk("R1 all conditions at once", evt_o, 8'h0F);
    lcl_press_i = 1'b1; step(); lcl_press_i = 1'b0;
    chk("R1 local bit 7", evt_o, 8'h8F);
    chk("R9 srq on extra bit", srq_o, 1'b1);
    cond_i = 4'b0000; step();
    chk("R2 reserved event bits", evt_o, 8'h8F);
    chk("R9 no srq on re-hit", srq_o, 1'b0);
    clear_all();
  endtask

  task automatic t_coincident();
    wr_en(8'h0F);
    cond_i = 4'b0001; step();
    cond_i = 4'b0101;
    evt_rd_i = 1'b1;
    chk("R7 read value before clear", evt_o, 8'h01);
    step();
    evt_rd_i = 1'b0;
    chk("R8 change during read kept", evt_o, 8'h04);
    chk("R9 srq for kept change", srq_o, 1'b1);
    clr_i = 1'b1; cond_i = 4'b0001;
    step();
    clr_i = 1'b0;
    chk("R8 change during clear kept", evt_o, 8'h04);
    chk("R9 no srq for re-hit bit", srq_o, 1'b0);
    cond_i = 4'b0000; step();
    clear_all();
    chk("R7 clear leaves zero", evt_o, 8'h00);
  endtask

  task automatic t_zero_en();
    wr_en(8'h00);
    cond_i = 4'b1111; lcl_press_i = 1'b1; step(); lcl_press_i = 1'b0;
    chk("R10 no event", evt_o, 8'h00);
    chk("R10 no srq", srq_o, 1'b0);
    cond_i = 4'b0000; step();
    chk("R10 no event falling", evt_o, 8'h00);
    chk("R10 no srq falling", srq_o, 1'b0);
  endtask

  task automatic t_mid_reset();
    wr_en(8'h8F);
    cond_i = 4'b0010; step();
    rst_i = 1'b1; step(); rst_i = 1'b0;
    cond_i = 4'b0000;
    chk("R11 evt cleared by reset", evt_o, 8'h00);
    chk("R11 en cleared by reset", en_o, 8'h00);
    chk("R11 srq cleared by reset", srq_o, 1'b0);
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_enable();
    t_mask_edges();
    t_falling();
    t_local();
    t_multi();
    t_coincident();
    t_zero_en();
    t_mid_reset();
    report();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule